// File: doc/BRIEF.md
# Exception and interrupt aggregation registers

This block is a byte-wide register file on an 8-bit control bus. It gathers the error conditions of the bus itself and of the physical interface into an exception status register. It qualifies them with an exception mask and merges them with pre-masked summary inputs from other event sources into a read-only interrupt condition register. A final interrupt mask qualifies that register and drives one active-low interrupt pin.

The block also polices the bus. A write whose parity is wrong is dropped. An access to a parameter byte that is locked in the current operating mode is refused. A write to a conditionally writable register is performed only when a shadow compare register still equals the target's current contents. Each outcome is reported in the exception status register. The inhibit flag raised by a failed conditional write is visible to software but can never raise an interrupt.

Bus accesses are single-cycle requests. Write data is odd parity over nine bits (`bus_wdata` and `bus_wpar`). Read data is registered.

Top module: `exc_irq_regs`

## Requirements
- R1: After reset the exception status (00h), exception mask (01h) and interrupt mask (03h) registers read 00h, `int_n` is high and `bus_rdata` is 00h.
- R2: A write to a conditional register at 08h+i (i < NCOND) stores the data only when the compare register (04h) equals that register's current value. On a mismatch the register keeps its value and status bit 7 is set. On a match, status bit 7 is cleared.
- R3: A refused access is not performed and sets status bit 6 (command error). A refused read returns 00h.
- R4: While `bus_par_en` is high, a write whose nine bits {`bus_wdata`,`bus_wpar`} have even parity sets status bits 5 and 6 and is dropped. While `bus_par_en` is low, parity is not checked and the write is performed.
- R5: A one-cycle `if_par_err` pulse sets status bit 0 only while `if_par_en` is high.
- R6: Status bits 6, 5 and 0 stay set until software writes a one to that bit position at 00h. Bit 7 is not affected by writes to 00h. Bits 4:1 read 0.
- R7: The exception mask at 01h holds bits 6, 5 and 0; all its other bits read 0. Interrupt condition bit 7 is the OR of status AND mask, so status bit 7 never reaches it.
- R8: The interrupt condition at 02h is read-only, and writes to it have no effect and raise no error. Its bits are:
  - bit 7: exception event;
  - bit 6: OR of `intern_evt`;
  - bit 3: `co_evt`;
  - bit 2: `ci_evt`;
  - bit 1: `tt_evt`;
  - bit 0: `ring_evt`;
  - bits 5:4: zero.
- R9: The interrupt mask at 03h holds bits 7, 6 and 3:0. One cycle after some condition bit and its mask bit are both one, `int_n` is low. One cycle after no such pair exists, `int_n` is high.
- R10: Parameter bytes at 40h+j (j < NPARAM) are open whenever `running` is low. While `running` is high they are open only when all of these hold:
  - `xmit_state` is 0, 1 or 3;
  - both `opt_bits` are set;
  - both `func_bits` are clear.
  Otherwise the access is refused (R3).
- R11: Read data appears on `bus_rdata` one cycle after the read request and holds until the next read. The compare register at 04h is always readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wpar | input | 1 | Odd parity bit over write data |
| bus_rdata | output | 8 | Registered read data |
| bus_par_en | input | 1 | Enables bus write parity checking |
| if_par_en | input | 1 | Enables recording of interface parity errors |
| if_par_err | input | 1 | Interface parity error pulse |
| running | input | 1 | Operating (1) or stopped (0) |
| xmit_state | input | XS_W | Transmitter state number |
| opt_bits | input | 2 | Option bits that must both be set while running |
| func_bits | input | 2 | Function bits that must both be clear while running |
| ring_evt | input | 1 | Pre-masked ring event summary |
| tt_evt | input | 1 | Pre-masked token/timer event summary |
| ci_evt | input | 1 | Pre-masked counter increment summary |
| co_evt | input | 1 | Pre-masked counter overflow summary |
| intern_evt | input | INTEV_W | Internal event bits |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: NCOND=2, NPARAM=8, XS_W=3 and INTEV_W=4. These give a 3-bit transmitter state, which reaches both the accepted states 0, 1 and 3 and the rejected state 2. The bench drives the conditional-write compare against the first conditional register and the mode gate against the first parameter byte. The four-bit internal event vector lets a single non-zero bit show that any one event raises condition bit 6.

// File: rtl/exc_irq_pkg.sv
package exc_irq_pkg;

  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;

  // Register map
  localparam logic [AW-1:0] ADR_EXC_STAT   = 8'h00;
  localparam logic [AW-1:0] ADR_EXC_MASK   = 8'h01;
  localparam logic [AW-1:0] ADR_INT_COND   = 8'h02;
  localparam logic [AW-1:0] ADR_INT_MASK   = 8'h03;
  localparam logic [AW-1:0] ADR_CMP        = 8'h04;
  localparam logic [AW-1:0] ADR_COND_BASE  = 8'h08;
  localparam logic [AW-1:0] ADR_PARAM_BASE = 8'h40;

  // Exception status bit positions
  localparam int unsigned EB_CWI  = 7;
  localparam int unsigned EB_CMD  = 6;
  localparam int unsigned EB_BPAR = 5;
  localparam int unsigned EB_IPAR = 0;

  // Interrupt condition bit positions
  localparam int unsigned IB_EXC    = 7;
  localparam int unsigned IB_INTERN = 6;
  localparam int unsigned IB_CO     = 3;
  localparam int unsigned IB_CI     = 2;
  localparam int unsigned IB_TT     = 1;
  localparam int unsigned IB_RING   = 0;

  localparam logic [DW-1:0] EXC_STICKY   = 8'h61;
  localparam logic [DW-1:0] EXC_MASKABLE = 8'h61;
  localparam logic [DW-1:0] INT_MASKABLE = 8'hCF;

  typedef struct packed {
    logic wr_en;
    logic rd_en;
    logic cmd_err;
    logic bpar_err;
  } acc_ctl_t;

  function automatic logic addr_in(input logic [AW-1:0] a,
                                   input logic [AW-1:0] base,
                                   input int unsigned   n);
    return (32'(a) >= 32'(base)) && (32'(a) < (32'(base) + n));
  endfunction

endpackage

// File: rtl/ecr_access_gate.sv
module ecr_access_gate
  import exc_irq_pkg::*;
#(
  parameter int unsigned NPARAM = 8,
  parameter int unsigned XS_W   = 3
) (
  input  logic            req_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            wpar_i,
  input  logic            bus_par_en_i,
  input  logic            running_i,
  input  logic [XS_W-1:0] xmit_state_i,
  input  logic [1:0]      opt_i,
  input  logic [1:0]      func_i,
  output acc_ctl_t        ctl_o,
  output logic            param_open_o
);

  localparam logic [XS_W-1:0] XS_IDLE0 = XS_W'(0);
  localparam logic [XS_W-1:0] XS_IDLE1 = XS_W'(1);
  localparam logic [XS_W-1:0] XS_IDLE3 = XS_W'(3);

  logic xs_ok;
  logic par_bad;
  logic blocked;
  logic refuse;

  always_comb begin
    xs_ok        = (xmit_state_i == XS_IDLE0) || (xmit_state_i == XS_IDLE1) ||
                   (xmit_state_i == XS_IDLE3);
    param_open_o = !running_i || (xs_ok && (&opt_i) && !(|func_i));
    // nine-bit odd parity: a good word has an odd count of ones
    par_bad      = req_i && wr_i && bus_par_en_i && !(^{wdata_i, wpar_i});
    blocked      = req_i && addr_in(addr_i, ADR_PARAM_BASE, NPARAM) && !param_open_o;
    refuse       = par_bad || blocked;
    ctl_o.bpar_err = par_bad;
    ctl_o.cmd_err  = refuse;
    ctl_o.wr_en    = req_i && wr_i && !refuse;
    ctl_o.rd_en    = req_i && !wr_i && !refuse;
  end

endmodule

// File: rtl/ecr_store.sv
module ecr_store
  import exc_irq_pkg::*;
#(
  parameter int unsigned NCOND  = 2,
  parameter int unsigned NPARAM = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          cwi_set_o,
  output logic          cwi_clr_o
);

  logic [DW-1:0]     cmp_q;
  logic [DW-1:0]     cmp_d;
  logic              cmp_en;
  logic [DW-1:0]     cond_q [NCOND];
  logic [NCOND-1:0]  cond_sel;
  logic [NCOND-1:0]  cond_match;
  logic [DW-1:0]     prm_q [NPARAM];
  logic [NPARAM-1:0] prm_sel;

  // next-state and enables
  always_comb begin
    cmp_en = wr_en_i && (addr_i == ADR_CMP);
    cmp_d  = wdata_i;
    for (int i = 0; i < int'(NCOND); i++) begin
      cond_sel[i]   = wr_en_i && (addr_i == AW'(32'(ADR_COND_BASE) + 32'(i)));
      cond_match[i] = (cmp_q == cond_q[i]);
    end
    for (int j = 0; j < int'(NPARAM); j++) begin
      prm_sel[j] = wr_en_i && (addr_i == AW'(32'(ADR_PARAM_BASE) + 32'(j)));
    end
    cwi_set_o = |(cond_sel & ~cond_match);
    cwi_clr_o = |(cond_sel & cond_match);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else if (cmp_en) begin
      cmp_q <= cmp_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NCOND); i++) cond_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(NCOND); i++) begin
        if (cond_sel[i] && cond_match[i]) cond_q[i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < int'(NPARAM); j++) prm_q[j] <= '0;
    end else begin
      for (int j = 0; j < int'(NPARAM); j++) begin
        if (prm_sel[j]) prm_q[j] <= wdata_i;
      end
    end
  end

  // read selection
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_CMP) rdata_o = cmp_q;
    for (int i = 0; i < int'(NCOND); i++) begin
      if (addr_i == AW'(32'(ADR_COND_BASE) + 32'(i))) rdata_o = cond_q[i];
    end
    for (int j = 0; j < int'(NPARAM); j++) begin
      if (addr_i == AW'(32'(ADR_PARAM_BASE) + 32'(j))) rdata_o = prm_q[j];
    end
  end

  // R2: a compare mismatch leaves the target untouched
  for (genvar gi = 0; gi < int'(NCOND); gi++) begin : g_chk
    a_r2_hold_on_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cond_sel[gi] && !cond_match[gi]) |=> $stable(cond_q[gi]));
  end

endmodule

// File: rtl/ecr_exc_status.sv
module ecr_exc_status
  import exc_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stat_i,
  input  logic          wr_mask_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          set_cmd_i,
  input  logic          set_bpar_i,
  input  logic          set_ipar_i,
  input  logic          cwi_set_i,
  input  logic          cwi_clr_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic          exc_evt_o
);

  localparam logic [DW-1:0] STAT_LIVE = EXC_STICKY | (DW'(1) << EB_CWI);

  logic [DW-1:0] stat_q, stat_d;
  logic          stat_en;
  logic [DW-1:0] mask_q, mask_d;
  logic          mask_en;

  always_comb begin
    stat_d = stat_q;
    if (wr_stat_i) stat_d = stat_d & ~(wdata_i & EXC_STICKY);
    // new events win over a clear in the same cycle
    if (set_cmd_i)  stat_d[EB_CMD]  = 1'b1;
    if (set_bpar_i) stat_d[EB_BPAR] = 1'b1;
    if (set_ipar_i) stat_d[EB_IPAR] = 1'b1;
    if (cwi_set_i)      stat_d[EB_CWI] = 1'b1;
    else if (cwi_clr_i) stat_d[EB_CWI] = 1'b0;
    stat_d  = stat_d & STAT_LIVE;
    stat_en = (stat_d != stat_q);
    mask_en = wr_mask_i;
    mask_d  = wdata_i & EXC_MASKABLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign stat_o    = stat_q;
  assign mask_o    = mask_q;
  assign exc_evt_o = |(stat_q & mask_q);

  a_r6_sticky_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[EB_CMD] && !(wr_stat_i && wdata_i[EB_CMD])) |=> stat_q[EB_CMD]);

  a_r6_sticky_ipar: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[EB_IPAR] && !(wr_stat_i && wdata_i[EB_IPAR])) |=> stat_q[EB_IPAR]);

  a_r2_inhibit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwi_set_i |=> stat_q[EB_CWI]);

  a_r2_inhibit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwi_clr_i |=> !stat_q[EB_CWI]);

endmodule

// File: rtl/ecr_irq_agg.sv
module ecr_irq_agg
  import exc_irq_pkg::*;
#(
  parameter int unsigned INTEV_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_evt_i,
  input  logic [INTEV_W-1:0] intern_evt_i,
  input  logic               ring_evt_i,
  input  logic               tt_evt_i,
  input  logic               ci_evt_i,
  input  logic               co_evt_i,
  input  logic               wr_imask_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      cond_o,
  output logic [DW-1:0]      imask_o,
  output logic               int_n_o
);

  logic [DW-1:0] imask_q, imask_d;
  logic          imask_en;
  logic          int_n_q, int_n_d;

  always_comb begin
    cond_o             = '0;
    cond_o[IB_EXC]     = exc_evt_i;
    cond_o[IB_INTERN]  = |intern_evt_i;
    cond_o[IB_CO]      = co_evt_i;
    cond_o[IB_CI]      = ci_evt_i;
    cond_o[IB_TT]      = tt_evt_i;
    cond_o[IB_RING]    = ring_evt_i;
    imask_en = wr_imask_i;
    imask_d  = wdata_i & INT_MASKABLE;
    int_n_d  = !(|(cond_o & imask_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= '0;
    end else if (imask_en) begin
      imask_q <= imask_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_n_q <= 1'b1;
    end else begin
      int_n_q <= int_n_d;
    end
  end

  assign imask_o = imask_q;
  assign int_n_o = int_n_q;

  a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask_q == '0) |=> int_n_q);

  a_r9_low_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_n_q |-> ($past(imask_q) != '0));

endmodule

// File: rtl/exc_irq_regs.sv
module exc_irq_regs
  import exc_irq_pkg::*;
#(
  parameter int unsigned NCOND   = 2,
  parameter int unsigned NPARAM  = 8,
  parameter int unsigned XS_W    = 3,
  parameter int unsigned INTEV_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wpar,
  output logic [7:0]         bus_rdata,
  input  logic               bus_par_en,
  input  logic               if_par_en,
  input  logic               if_par_err,
  input  logic               running,
  input  logic [XS_W-1:0]    xmit_state,
  input  logic [1:0]         opt_bits,
  input  logic [1:0]         func_bits,
  input  logic               ring_evt,
  input  logic               tt_evt,
  input  logic               ci_evt,
  input  logic               co_evt,
  input  logic [INTEV_W-1:0] intern_evt,
  output logic               int_n
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe[1];

  acc_ctl_t      ctl;
  logic          param_open;
  logic [DW-1:0] st_rdata;
  logic          cwi_set, cwi_clr;
  logic [DW-1:0] stat, emask, cond, imask;
  logic          exc_evt;
  logic          wr_stat, wr_emask, wr_imask;
  logic [DW-1:0] rd_mux, rdata_q, rdata_d;
  logic          rdata_en;

  ecr_access_gate #(.NPARAM(NPARAM), .XS_W(XS_W)) u_gate (
    .req_i        (bus_req),
    .wr_i         (bus_wr),
    .addr_i       (bus_addr),
    .wdata_i      (bus_wdata),
    .wpar_i       (bus_wpar),
    .bus_par_en_i (bus_par_en),
    .running_i    (running),
    .xmit_state_i (xmit_state),
    .opt_i        (opt_bits),
    .func_i       (func_bits),
    .ctl_o        (ctl),
    .param_open_o (param_open)
  );

  ecr_store #(.NCOND(NCOND), .NPARAM(NPARAM)) u_store (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (ctl.wr_en),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .rdata_o   (st_rdata),
    .cwi_set_o (cwi_set),
    .cwi_clr_o (cwi_clr)
  );

  always_comb begin
    wr_stat  = ctl.wr_en && (bus_addr == ADR_EXC_STAT);
    wr_emask = ctl.wr_en && (bus_addr == ADR_EXC_MASK);
    wr_imask = ctl.wr_en && (bus_addr == ADR_INT_MASK);
  end

  ecr_exc_status u_exc (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_stat_i  (wr_stat),
    .wr_mask_i  (wr_emask),
    .wdata_i    (bus_wdata),
    .set_cmd_i  (ctl.cmd_err),
    .set_bpar_i (ctl.bpar_err),
    .set_ipar_i (if_par_err && if_par_en),
    .cwi_set_i  (cwi_set),
    .cwi_clr_i  (cwi_clr),
    .stat_o     (stat),
    .mask_o     (emask),
    .exc_evt_o  (exc_evt)
  );

  ecr_irq_agg #(.INTEV_W(INTEV_W)) u_irq (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .exc_evt_i    (exc_evt),
    .intern_evt_i (intern_evt),
    .ring_evt_i   (ring_evt),
    .tt_evt_i     (tt_evt),
    .ci_evt_i     (ci_evt),
    .co_evt_i     (co_evt),
    .wr_imask_i   (wr_imask),
    .wdata_i      (bus_wdata),
    .cond_o       (cond),
    .imask_o      (imask),
    .int_n_o      (int_n)
  );

  // read path
  always_comb begin
    case (bus_addr)
      ADR_EXC_STAT: rd_mux = stat;
      ADR_EXC_MASK: rd_mux = emask;
      ADR_INT_COND: rd_mux = cond;
      ADR_INT_MASK: rd_mux = imask;
      default:      rd_mux = st_rdata;
    endcase
    rdata_en = bus_req && !bus_wr;
    rdata_d  = ctl.rd_en ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end
  assign bus_rdata = rdata_q;

  a_r3_refused_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_req && !param_open && addr_in(bus_addr, ADR_PARAM_BASE, NPARAM))
      |=> stat[EB_CMD]);

  a_r4_parity_flags: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_req && bus_wr && bus_par_en && !(^{bus_wdata, bus_wpar}))
      |=> (stat[EB_BPAR] && stat[EB_CMD]));

  a_r5_ipar_capture: assert property (@(posedge clk) disable iff (!rst_ni)
    (if_par_err && if_par_en) |=> stat[EB_IPAR]);

  a_r7_inhibit_isolated: assert property (@(posedge clk) disable iff (!rst_ni)
    ((stat & emask & 8'h7F) == '0) |-> !cond[IB_EXC]);

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_req && !bus_wr) |=> $stable(bus_rdata));

endmodule

// File: tb/sim_exc_irq_regs.sv
`timescale 1ns/1ps
module sim_exc_irq_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_req = 1'b0, bus_wr = 1'b0, bus_wpar = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_par_en = 1'b1, if_par_en = 1'b1, if_par_err = 1'b0;
  logic       running = 1'b0;
  logic [2:0] xmit_state = '0;
  logic [1:0] opt_bits = 2'b11, func_bits = 2'b00;
  logic       ring_evt = 1'b0, tt_evt = 1'b0, ci_evt = 1'b0, co_evt = 1'b0;
  logic [3:0] intern_evt = '0;
  logic       int_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  exc_irq_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wpar(bus_wpar),
    .bus_rdata(bus_rdata), .bus_par_en(bus_par_en), .if_par_en(if_par_en),
    .if_par_err(if_par_err), .running(running), .xmit_state(xmit_state),
    .opt_bits(opt_bits), .func_bits(func_bits), .ring_evt(ring_evt),
    .tt_evt(tt_evt), .ci_evt(ci_evt), .co_evt(co_evt),
    .intern_evt(intern_evt), .int_n(int_n)
  );

  // kind: 0 write good parity, 1 write bad parity, 2 read and compare
  // fields {kind, addr, data, expected, requirement}
  localparam int NV = 30;
  localparam logic [29:0] VEC [NV] = '{
    {2'd2, 8'h00, 8'h00, 8'h00, 4'd1},   // R1 status
    {2'd2, 8'h01, 8'h00, 8'h00, 4'd1},   // R1 exception mask
    {2'd2, 8'h03, 8'h00, 8'h00, 4'd1},   // R1 interrupt mask
    {2'd0, 8'h04, 8'h00, 8'h00, 4'd11},  // R11 compare write
    {2'd0, 8'h08, 8'h5A, 8'h00, 4'd2},   // R2 match write
    {2'd2, 8'h08, 8'h00, 8'h5A, 4'd2},
    {2'd2, 8'h00, 8'h00, 8'h00, 4'd2},
    {2'd0, 8'h08, 8'h11, 8'h00, 4'd2},   // R2 mismatch
    {2'd2, 8'h08, 8'h00, 8'h5A, 4'd2},
    {2'd2, 8'h00, 8'h00, 8'h80, 4'd2},
    {2'd0, 8'h04, 8'h5A, 8'h00, 4'd11},
    {2'd2, 8'h04, 8'h00, 8'h5A, 4'd11},  // R11 compare readback
    {2'd0, 8'h08, 8'h11, 8'h00, 4'd2},   // R2 match clears inhibit
    {2'd2, 8'h08, 8'h00, 8'h11, 4'd2},
    {2'd2, 8'h00, 8'h00, 8'h00, 4'd2},
    {2'd0, 8'h40, 8'h3C, 8'h00, 4'd10},  // R10 stopped access
    {2'd2, 8'h40, 8'h00, 8'h3C, 4'd10},
    {2'd0, 8'h01, 8'hFF, 8'h00, 4'd7},   // R7 mask width
    {2'd2, 8'h01, 8'h00, 8'h61, 4'd7},
    {2'd0, 8'h03, 8'hFF, 8'h00, 4'd9},   // R9 mask width
    {2'd2, 8'h03, 8'h00, 8'hCF, 4'd9},
    {2'd1, 8'h04, 8'h77, 8'h00, 4'd4},   // R4 bad parity dropped
    {2'd2, 8'h04, 8'h00, 8'h5A, 4'd4},
    {2'd2, 8'h00, 8'h00, 8'h60, 4'd4},
    {2'd0, 8'h00, 8'h20, 8'h00, 4'd6},   // R6 clear one bit
    {2'd2, 8'h00, 8'h00, 8'h40, 4'd6},
    {2'd0, 8'h00, 8'hC0, 8'h00, 4'd6},
    {2'd2, 8'h00, 8'h00, 8'h00, 4'd6},
    {2'd0, 8'h02, 8'hFF, 8'h00, 4'd8},   // R8 write ignored
    {2'd2, 8'h02, 8'h00, 8'h00, 4'd8}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] a, input logic [7:0] d, input logic good);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    bus_wpar = good ? ~(^d) : (^d);
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    acc(1'b1, a, d, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    acc(1'b0, a, 8'h00, 1'b1);
    d = bus_rdata;
  endtask

  task automatic pulse_ipar();
    @(negedge clk); if_par_err = 1'b1;
    @(negedge clk); if_par_err = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 int_n after reset", {7'b0, int_n}, 8'h01);
    check("R1 rdata after reset", bus_rdata, 8'h00);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][29:28] == 2'd2) begin
        rd(VEC[k][27:20], rv);
        check($sformatf("R%0d vector %0d", VEC[k][3:0], k), rv, VEC[k][11:4]);
      end else begin
        acc(1'b1, VEC[k][27:20], VEC[k][19:12], VEC[k][29:28] == 2'd0);
      end
    end

    // R5 interface parity gated by its enable
    if_par_en = 1'b0; pulse_ipar();
    rd(8'h00, rv); check("R5 disabled pulse", rv, 8'h00);
    if_par_en = 1'b1; pulse_ipar();
    rd(8'h00, rv); check("R5 enabled pulse", rv, 8'h01);
    check("R9 int_n low on masked exception", {7'b0, int_n}, 8'h00);
    wr(8'h00, 8'h01);
    rd(8'h00, rv); check("R6 clear interface parity", rv, 8'h00);
    check("R9 int_n released", {7'b0, int_n}, 8'h01);

    // R8 condition layout from summary inputs
    @(negedge clk); ring_evt = 1'b1; ci_evt = 1'b1; intern_evt = 4'b0100;
    rd(8'h02, rv); check("R8 condition layout", rv, 8'h45);
    check("R9 int_n low on summary event", {7'b0, int_n}, 8'h00);
    wr(8'h03, 8'h00); @(negedge clk);
    check("R9 all masked", {7'b0, int_n}, 8'h01);
    wr(8'h03, 8'h04); @(negedge clk);
    check("R9 counter increment unmasked", {7'b0, int_n}, 8'h00);
    wr(8'h03, 8'h08); @(negedge clk);
    check("R9 other bit unmasked", {7'b0, int_n}, 8'h01);
    @(negedge clk); ring_evt = 1'b0; ci_evt = 1'b0; intern_evt = '0;
    wr(8'h03, 8'h80);

    // R7 inhibit flag never interrupts
    wr(8'h08, 8'h22);
    rd(8'h08, rv); check("R2 inhibited write", rv, 8'h11);
    rd(8'h00, rv); check("R2 inhibit flag", rv, 8'h80);
    rd(8'h02, rv); check("R7 inhibit excluded from condition", rv, 8'h00);
    check("R7 int_n stays high", {7'b0, int_n}, 8'h01);
    wr(8'h00, 8'h80);
    rd(8'h00, rv); check("R6 inhibit ignores clear", rv, 8'h80);
    wr(8'h04, 8'h11); wr(8'h08, 8'h22);
    rd(8'h08, rv); check("R2 matched write", rv, 8'h22);
    rd(8'h00, rv); check("R2 inhibit cleared", rv, 8'h00);

    // R10 and R3 parameter gating while running
    running = 1'b1; xmit_state = 3'd2; opt_bits = 2'b11; func_bits = 2'b00;
    rd(8'h40, rv); check("R3 refused read data", rv, 8'h00);
    rd(8'h00, rv); check("R3 command error", rv, 8'h40);
    wr(8'h00, 8'h40);
    xmit_state = 3'd3;
    rd(8'h40, rv); check("R10 open in state 3", rv, 8'h3C);
    rd(8'h00, rv); check("R10 no error when open", rv, 8'h00);
    xmit_state = 3'd0; opt_bits = 2'b01;
    wr(8'h40, 8'h99);
    rd(8'h00, rv); check("R10 option bit clear refused", rv, 8'h40);
    wr(8'h00, 8'h40);
    xmit_state = 3'd1; opt_bits = 2'b11;
    rd(8'h40, rv); check("R3 refused write not performed", rv, 8'h3C);
    func_bits = 2'b10;
    rd(8'h40, rv); check("R10 function bit set refused", rv, 8'h00);
    rd(8'h00, rv); check("R10 function bit error", rv, 8'h40);
    wr(8'h00, 8'h40);
    running = 1'b0;
    rd(8'h40, rv); check("R10 stopped open", rv, 8'h3C);
    rd(8'h00, rv); check("R10 stopped no error", rv, 8'h00);

    // R4 checking disabled
    bus_par_en = 1'b0;
    acc(1'b1, 8'h04, 8'h33, 1'b0);
    rd(8'h04, rv); check("R4 unchecked write performed", rv, 8'h33);
    rd(8'h00, rv); check("R4 no error when unchecked", rv, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule